// File: doc/BRIEF.md
# Systolic Forward-Differencing Scanline Array

This block is a chain of identical processing elements, one per pixel of a scanline. It evaluates polynomial shading functions by forward differencing. A single token stream enters element 0. Each token carries a 4-bit opcode and a 36-bit data word. On every clock edge each token moves one element to the right, and each element acts on the token it holds in that cycle.

The difference terms are not computed in one place. The tokens carry them along the pixels. When an addressed element receives an order-k difference token, it stores the carried value as its own order-k term. It then forwards that value plus its own order-(k+1) term, so the next pixel sees the next value of the running difference. The highest order is sent first. A cubic, quadratic, linear or constant function therefore takes one range token, then four, three, two or one difference tokens.

Each element also holds an accumulator. Accumulate tokens add the element's intensity into it, and a mode token can make negative intensities be skipped. A refresh token emits every accumulator on a pixel-serial port in pixel order. A clear token zeroes all accumulators.

Addressing travels with the token and needs no pixel index in the element. A range, mask or stride token carries a skip count in data[15:0] and a length or stride in data[31:16]. Each element decrements these fields as the token passes.

Top module: `sfd_scan_array`

## Requirements

- R1: A refresh token presented at the input in cycle C drives pixel p onto the output in cycle C+1+p, so each token advances exactly one element per clock.
- R2: A range token (opcode 1, skip s in data[15:0], length n in data[31:16]) arms exactly elements s to s+n-1 and disarms all others. Data tokens change no register of a disarmed element.
- R3: With a range from element 0, the opcodes D3=8, D2=7, D1=6 and D0=5 carrying 6, 8, 3 and 1 in that order give intensities 1, 4, 15, 40, 85, 156 and 259 on the seven armed pixels.
- R4: A range token zeroes the order-1 to order-3 difference terms of every element it arms, so quadratic and lower-order functions are not disturbed by terms left from earlier commands.
- R5: All intensity, difference and accumulator arithmetic is 36-bit two's complement and wraps on overflow.
- R6: An accumulate token (opcode 12) adds the intensity of each active element (armed and not masked) into its accumulator. Repeated accumulates sum.
- R7: After a mode token (opcode 4) with data[0]=1, accumulate skips every element whose intensity is negative. With data[0]=0, negative values are added.
- R8: A refresh token (opcode 13) raises the output valid strobe for NUM_PE consecutive cycles. It presents pixel indices 0 to NUM_PE-1 in order, each with that element's accumulator.
- R9: A clear token (opcode 14) zeroes the accumulator of every element, armed or not.
- R10: A mask token (opcode 3, same field layout as the range token) masks exactly the addressed elements and unmasks the rest. Masked elements ignore difference, set and accumulate tokens.
- R11: A stride token (opcode 2, start x in data[15:0], stride d in data[31:16]) arms elements x, x+d, x+2d and so on, and disarms the rest. Set opcodes 9, 10 and 11 write the carried value into the order-0, order-1 and order-2 term of every active element.
- R12: Element 0 is addressable. A skip of 0 writes pixel 0, with no offset between the addressed pixel and the pixel written.
- R13: During and after reset the output valid strobe is low, and every accumulator reads back as zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Systolic pulse clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tok_valid_i | input | 1 | A token enters element 0 this cycle |
| tok_op_i | input | 4 | Token opcode |
| tok_data_i | input | 36 | Token data word |
| pix_valid_o | output | 1 | Pixel output strobe |
| pix_idx_o | output | $clog2(NUM_PE) | Index of the pixel being output |
| pix_data_o | output | 36 | Accumulated intensity of that pixel |

## Verification

The output selector assumes that only one element holds a refresh token at a time. The pixel-ordering property relies on the same assumption, so refresh tokens must be at least NUM_PE cycles apart. The stimulus always waits for a full scanline of output before the next token. Difference tokens are assumed to arrive highest order first and back to back after their range token. Every scenario sends its tokens in that order, and each scenario first restores a known mode, mask and accumulator state.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  parameter int unsigned DW     = 36;  // datapath width
  parameter int unsigned FW     = 16;  // skip/span field width
  parameter int unsigned ORDERS = 3;   // highest difference order
  parameter int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP     = 4'd0,
    OP_RANGE   = 4'd1,
    OP_STRIDE  = 4'd2,
    OP_MASK    = 4'd3,
    OP_MODE    = 4'd4,
    OP_D0      = 4'd5,
    OP_D1      = 4'd6,
    OP_D2      = 4'd7,
    OP_D3      = 4'd8,
    OP_SET0    = 4'd9,
    OP_SET1    = 4'd10,
    OP_SET2    = 4'd11,
    OP_ACC     = 4'd12,
    OP_REFRESH = 4'd13,
    OP_CLEAR   = 4'd14
  } sfd_op_e;

  typedef struct packed {
    logic          vld;
    sfd_op_e       op;
    logic [DW-1:0] data;
  } sfd_tok_t;
endpackage

// File: rtl/sfd_pe.sv
module sfd_pe
  import sfd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sfd_tok_t      tok_i,
  output sfd_tok_t      tok_o,
  output logic          refresh_o,
  output logic [DW-1:0] acc_o
);
  localparam logic [FW-1:0] ONE_F = FW'(1);

  sfd_tok_t      tok_q;
  logic          armed_q, mask_q, clip_q;
  logic          armed_d, mask_d, clip_d;
  logic [DW-1:0] ord_q [ORDERS+1];
  logic [DW-1:0] ord_d [ORDERS+1];
  logic [DW-1:0] up    [ORDERS+1];
  logic [DW-1:0] acc_q, acc_d;
  logic [FW-1:0] skip, span;
  logic [OP_W-1:0] opn;
  logic          hit, active;
  sfd_tok_t      fwd;

  assign active = armed_q & ~mask_q;
  assign skip   = tok_q.data[FW-1:0];
  assign span   = tok_q.data[2*FW-1:FW];
  assign opn    = tok_q.op;

  // next-higher difference term seen by each order; top order adds nothing
  always_comb begin
    for (int k = 0; k < ORDERS; k++) up[k] = ord_q[k+1];
    up[ORDERS] = '0;
  end

  always_comb begin
    armed_d = armed_q;
    mask_d  = mask_q;
    clip_d  = clip_q;
    ord_d   = ord_q;
    acc_d   = acc_q;
    fwd     = tok_q;
    hit     = 1'b0;
    if (tok_q.vld) begin
      case (tok_q.op)
        OP_RANGE, OP_MASK: begin
          if (skip != '0) begin
            fwd.data[FW-1:0] = skip - ONE_F;
          end else if (span != '0) begin
            hit = 1'b1;
            fwd.data[2*FW-1:FW] = span - ONE_F;
          end
          if (tok_q.op == OP_RANGE) begin
            armed_d = hit;
            if (hit) for (int k = 1; k <= ORDERS; k++) ord_d[k] = '0;
          end else begin
            mask_d = hit;
          end
        end
        OP_STRIDE: begin
          if (skip != '0) begin
            armed_d = 1'b0;
            fwd.data[FW-1:0] = skip - ONE_F;
          end else begin
            armed_d = 1'b1;
            fwd.data[FW-1:0] = (span == '0) ? '1 : span - ONE_F;
          end
        end
        OP_MODE:  clip_d = tok_q.data[0];
        OP_ACC: begin
          if (active && !(clip_q && ord_q[0][DW-1])) acc_d = acc_q + ord_q[0];
        end
        OP_CLEAR: acc_d = '0;
        default: begin
          for (int k = 0; k <= ORDERS; k++) begin
            if (opn == OP_W'(int'(OP_D0) + k) && active) begin
              ord_d[k] = tok_q.data;
              fwd.data = tok_q.data + up[k];
            end
          end
          for (int k = 0; k < ORDERS; k++) begin
            if (opn == OP_W'(int'(OP_SET0) + k) && active) ord_d[k] = tok_q.data;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q   <= '0;
      armed_q <= 1'b0;
      mask_q  <= 1'b0;
      clip_q  <= 1'b0;
      acc_q   <= '0;
      for (int k = 0; k <= ORDERS; k++) ord_q[k] <= '0;
    end else begin
      tok_q   <= tok_i;
      armed_q <= armed_d;
      mask_q  <= mask_d;
      clip_q  <= clip_d;
      acc_q   <= acc_d;
      for (int k = 0; k <= ORDERS; k++) ord_q[k] <= ord_d[k];
    end
  end

  assign tok_o     = fwd;
  assign refresh_o = tok_q.vld && (tok_q.op == OP_REFRESH);
  assign acc_o     = acc_q;

  a_r9_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_q.vld && tok_q.op == OP_CLEAR |=> acc_q == '0);

  a_r6_acc_only_on_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_q.vld && tok_q.op != OP_ACC && tok_q.op != OP_CLEAR |=> $stable(acc_q));

  a_r7_clip_skips_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_q.vld && tok_q.op == OP_ACC && clip_q && ord_q[0][DW-1] |=> $stable(acc_q));

  a_r10_masked_keeps_intensity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_q.vld && mask_q && (tok_q.op == OP_D0 || tok_q.op == OP_SET0) |=> $stable(ord_q[0]));
endmodule

// File: rtl/sfd_refresh_sel.sv
module sfd_refresh_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned DW    = 36,
  parameter int unsigned PIX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic [DW-1:0]    acc_i [N],
  output logic             valid_o,
  output logic [PIX_W-1:0] idx_o,
  output logic [DW-1:0]    data_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    data_o  = '0;
    for (int p = N - 1; p >= 0; p--) begin
      if (req_i[p]) begin
        valid_o = 1'b1;
        idx_o   = PIX_W'(p);
        data_o  = acc_i[p];
      end
    end
  end

  // input rule: refresh tokens spaced by at least N pulses
  a_r8_single_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_i));
endmodule

// File: rtl/sfd_scan_array.sv
module sfd_scan_array
  import sfd_pkg::*;
#(
  parameter int unsigned NUM_PE = 8,
  localparam int unsigned PIX_W = $clog2(NUM_PE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  input  logic [OP_W-1:0]  tok_op_i,
  input  logic [DW-1:0]    tok_data_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_idx_o,
  output logic [DW-1:0]    pix_data_o
);
  sfd_tok_t      chain [NUM_PE+1];
  logic [NUM_PE-1:0] refresh;
  logic [DW-1:0] acc [NUM_PE];

  assign chain[0] = '{vld: tok_valid_i, op: sfd_op_e'(tok_op_i), data: tok_data_i};

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    sfd_pe u_pe (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tok_i     (chain[p]),
      .tok_o     (chain[p+1]),
      .refresh_o (refresh[p]),
      .acc_o     (acc[p])
    );
  end

  sfd_refresh_sel #(.N(NUM_PE), .DW(DW), .PIX_W(PIX_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (refresh),
    .acc_i   (acc),
    .valid_o (pix_valid_o),
    .idx_o   (pix_idx_o),
    .data_o  (pix_data_o)
  );

  a_r8_pixel_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_idx_o != PIX_W'(NUM_PE - 1)
    |=> pix_valid_o && pix_idx_o == $past(pix_idx_o) + PIX_W'(1));

  a_r1_tail_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_idx_o == PIX_W'(NUM_PE - 1)
    |-> chain[NUM_PE].vld && chain[NUM_PE].op == OP_REFRESH && chain[NUM_PE].data == chain[NUM_PE-1].data);
endmodule

// File: tb/tb_sfd_scan_array.sv
`timescale 1ns/1ps
module tb_sfd_scan_array;
  localparam int N = 8;
  localparam int PW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tok_valid_i = 1'b0;
  logic [3:0]    tok_op_i = '0;
  logic [35:0]   tok_data_i = '0;
  logic          pix_valid_o;
  logic [PW-1:0] pix_idx_o;
  logic [35:0]   pix_data_o;

  int n_chk = 0, n_err = 0, cyc = 0, n_got = 0;
  logic [35:0] got [N];
  int          got_cyc [N];
  logic [35:0] exp_v [N];

  sfd_scan_array #(.NUM_PE(N)) dut (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (pix_valid_o) begin
    got[pix_idx_o]     = pix_data_o;
    got_cyc[pix_idx_o] = cyc;
    n_got++;
  end

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [35:0] data);
    @(negedge clk_i);
    tok_valid_i = 1'b1; tok_op_i = op; tok_data_i = data;
  endtask

  task automatic idle();
    @(negedge clk_i);
    tok_valid_i = 1'b0; tok_op_i = '0; tok_data_i = '0;
  endtask

  function automatic logic [35:0] fld(input int s, input int n);
    return {4'h0, 16'(n), 16'(s)};
  endfunction

  task automatic prep();
    send(4'd3, fld(0, 0));  // unmask all
    send(4'd4, 36'd0);      // clip off
    send(4'd14, 36'd0);     // clear
  endtask

  task automatic refresh_check(input string req);
    int c0;
    n_got = 0;
    send(4'd13, 36'd0);
    c0 = cyc;
    idle();
    repeat (N + 1) @(negedge clk_i);
    check({req, "/R8 count"}, 36'(n_got), 36'(N));
    for (int p = 0; p < N; p++) begin
      check(req, got[p], exp_v[p]);
      check("R1 latency", 36'(got_cyc[p] - c0), 36'(1 + p));
    end
  endtask

  task automatic t_reset();
    check("R13 valid low in reset", 36'(pix_valid_o), 36'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R13 valid low after reset", 36'(pix_valid_o), 36'd0);
    for (int p = 0; p < N; p++) exp_v[p] = '0;
    refresh_check("R13 acc zero");
  endtask

  task automatic t_cubic();
    prep();
    send(4'd1, fld(0, 7));
    send(4'd8, 36'd6); send(4'd7, 36'd8); send(4'd6, 36'd3); send(4'd5, 36'd1);
    send(4'd12, 36'd0);
    idle();
    exp_v = '{36'd1, 36'd4, 36'd15, 36'd40, 36'd85, 36'd156, 36'd259, 36'd0};
    refresh_check("R3 cubic");
    check("R12 pixel0 written", got[0], 36'd1);
  endtask

  task automatic t_quadratic();
    prep();
    send(4'd1, fld(2, 4));
    send(4'd7, 36'd2); send(4'd6, 36'd1); send(4'd5, 36'd5);
    send(4'd12, 36'd0);
    idle();
    exp_v = '{36'd0, 36'd0, 36'd5, 36'd6, 36'd9, 36'd14, 36'd0, 36'd0};
    refresh_check("R4/R2 quadratic range");
  endtask

  task automatic t_clip();
    prep();
    send(4'd4, 36'd1);
    send(4'd1, fld(0, 8));
    send(4'd6, 36'(-3)); send(4'd5, 36'd10);
    send(4'd12, 36'd0);
    idle();
    for (int p = 0; p < N; p++) exp_v[p] = (10 - 3 * p < 0) ? 36'd0 : 36'(10 - 3 * p);
    refresh_check("R7 clip");
  endtask

  task automatic t_double_acc();
    prep();
    send(4'd1, fld(0, 8));
    send(4'd6, 36'(-3)); send(4'd5, 36'd10);
    send(4'd12, 36'd0); send(4'd12, 36'd0);
    idle();
    for (int p = 0; p < N; p++) exp_v[p] = 36'(2 * (10 - 3 * p));
    refresh_check("R6 double accumulate");
  endtask

  task automatic t_wrap();
    prep();
    send(4'd1, fld(0, 2));
    send(4'd6, 36'd1); send(4'd5, 36'h7_FFFF_FFFF);
    send(4'd12, 36'd0);
    idle();
    for (int p = 0; p < N; p++) exp_v[p] = '0;
    exp_v[0] = 36'h7_FFFF_FFFF;
    exp_v[1] = 36'h8_0000_0000;
    refresh_check("R5 wrap");
  endtask

  task automatic t_mask();
    prep();
    send(4'd3, fld(3, 2));
    send(4'd1, fld(0, 8));
    send(4'd5, 36'd7);
    send(4'd12, 36'd0);
    idle();
    exp_v = '{36'd7, 36'd7, 36'd7, 36'd0, 36'd0, 36'd7, 36'd7, 36'd7};
    refresh_check("R10 mask");
  endtask

  task automatic t_stride();
    prep();
    send(4'd2, fld(1, 3));
    send(4'd9, 36'd9);
    send(4'd12, 36'd0);
    idle();
    exp_v = '{36'd0, 36'd9, 36'd0, 36'd0, 36'd9, 36'd0, 36'd0, 36'd9};
    refresh_check("R11 stride set");
  endtask

  task automatic t_clear();
    send(4'd14, 36'd0);
    idle();
    for (int p = 0; p < N; p++) exp_v[p] = '0;
    refresh_check("R9 clear");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    t_cubic();
    t_quadratic();
    t_clip();
    t_double_acc();
    t_wrap();
    t_mask();
    t_stride();
    t_clear();
    summary();
    $finish;
  end
endmodule